// File: doc/BRIEF.md
# Streaming Local-Alignment Scoring Unit

This block scores one short read against a window of a reference sequence that is streamed past it one base per clock. A linear array of cells holds the read, one base per cell. Every valid reference base advances the dynamic-programming matrix by one whole column. Each cell combines the diagonal value from the cell above, the left value it holds itself and the up value that ripples down the column. Scoring is local: a match adds two, a mismatch or a one-base gap costs one, and no cell value drops below zero.

A scheduler loads a read together with the two reference positions that bound its candidate region. The unit then waits until the stream reaches the first of those positions and scores every valid base up to and including the second. It keeps the highest cell value it has seen and the reference position of the column where that value first appeared. When the window closes it reports both with a one-cycle pulse and is ready for the next read.

Top module: `sw_stream_scorer`

## Requirements
- R1: After reset `busy` and `res_valid` are low.
- R2: A load (`load_valid` high) is taken only while `busy` is low, and `busy` is high from the next cycle on. A load offered while `busy` is high has no effect on the read, the window or the reported result.
- R3: Reference bases whose `ref_pos` comes before the window start are not scored, even when they would match the read.
- R4: Bases are coded A=0, C=1, G=2, T=3. Read base i sits in `load_read[2i+1:2i]`. A cell's value is the largest of: zero, the diagonal value plus 2 on a match or minus 1 on a mismatch, the left value minus 1, and the up value minus 1.
- R5: Only the first `load_len` read bases take part in scoring. Bases above that length have no effect.
- R6: The window is inclusive at both ends. Bases whose `ref_pos` comes after the window end are not scored.
- R7: The reported score is the largest cell value over the window. The reported position is the `ref_pos` of the earliest column that holds that value.
- R8: When no cell in the window is positive, the unit reports score 0 at the window start position.
- R9: `res_valid` is high for exactly one cycle. It starts on the cycle after the column at the window end is taken. In that cycle `busy` is already low, so a new read can be loaded at once.
- R10: A cycle with `ref_valid` low advances nothing: no column, no window progress, no change to the running best.
- R11: Scores are unsigned and wide enough for the largest local score. An exact match of a read of full length reports 2 × `load_len`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Offer of a new read and window |
| load_len | input | $clog2(READ_LEN_MAX+1) | Number of read bases in use |
| load_read | input | 2*READ_LEN_MAX | Read bases, two bits each, base 0 in the low bits |
| load_start | input | POS_W | First reference position of the window |
| load_end | input | POS_W | Last reference position of the window |
| ref_valid | input | 1 | Reference base present this cycle |
| ref_nt | input | 2 | Reference base code |
| ref_pos | input | POS_W | Reference position of `ref_nt` |
| busy | output | 1 | A read is loaded and its window is not yet closed |
| res_valid | output | 1 | One-cycle result pulse |
| res_score | output | $clog2(2*READ_LEN_MAX+1) | Best local score in the window |
| res_pos | output | POS_W | Reference position where the best score first appeared |

## Verification
The bench builds the unit with READ_LEN_MAX = 8 and POS_W = 16. At that size a read of full length fills every cell, so the top of the score range (16 in a 5-bit field) is reached by an exact match. A short window covers a whole alignment with gaps, mismatches and ties in a few dozen cycles. Each result is compared with a plain software matrix fill. The stimulus includes windows of a single column, windows that exclude matches just outside either end, stalled streams and loads offered while busy.

// File: rtl/sw_score_pkg.sv
package sw_score_pkg;

  typedef enum logic [1:0] {
    NT_A = 2'd0,
    NT_C = 2'd1,
    NT_G = 2'd2,
    NT_T = 2'd3
  } nt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SCORE = 2'd2
  } win_state_e;

  localparam int unsigned MATCH_GAIN    = 2;
  localparam int unsigned MISMATCH_COST = 1;
  localparam int unsigned GAP_COST      = 1;

endpackage

// File: rtl/sw_cell.sv
module sw_cell #(
  parameter int unsigned SC_W = 6,
  parameter int unsigned ROW  = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            step,
  input  logic            en,
  input  logic [1:0]      read_nt,
  input  logic [1:0]      ref_nt,
  input  logic [SC_W-1:0] diag_in,
  input  logic [SC_W-1:0] up_in,
  output logic [SC_W-1:0] h_new,
  output logic [SC_W-1:0] h_q
);
  import sw_score_pkg::*;

  localparam logic [SC_W-1:0] K_MATCH = SC_W'(MATCH_GAIN);
  localparam logic [SC_W-1:0] K_MISM  = SC_W'(MISMATCH_COST);
  localparam logic [SC_W-1:0] K_GAP   = SC_W'(GAP_COST);
  localparam logic [SC_W-1:0] ROW_CAP = SC_W'(MATCH_GAIN * (ROW + 1));

  function automatic logic [SC_W-1:0] sat_dec(input logic [SC_W-1:0] x,
                                               input logic [SC_W-1:0] k);
    return (x > k) ? (x - k) : '0;
  endfunction

  function automatic logic [SC_W-1:0] max2(input logic [SC_W-1:0] a,
                                            input logic [SC_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [SC_W-1:0] cell_next(input logic [SC_W-1:0] diag,
                                                 input logic [SC_W-1:0] up,
                                                 input logic [SC_W-1:0] left,
                                                 input logic            hit);
    logic [SC_W-1:0] d_term;
    d_term = hit ? (diag + K_MATCH) : sat_dec(diag, K_MISM);
    return max2(d_term, max2(sat_dec(up, K_GAP), sat_dec(left, K_GAP)));
  endfunction

  logic hit_w;
  assign hit_w = (read_nt == ref_nt);
  assign h_new = en ? cell_next(diag_in, up_in, h_q, hit_w) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)      h_q <= '0;
    else if (clear)  h_q <= '0;
    else if (step)   h_q <= h_new;
  end

  AST_CELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    h_q <= ROW_CAP); // R11
  AST_UNUSED_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (h_q == '0)); // R5

endmodule

// File: rtl/sw_window_ctrl.sv
module sw_window_ctrl #(
  parameter int unsigned POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [POS_W-1:0] load_start,
  input  logic [POS_W-1:0] load_end,
  input  logic             ref_valid,
  input  logic [POS_W-1:0] ref_pos,
  output logic             accept,
  output logic             step,
  output logic             last,
  output logic             busy,
  output logic [POS_W-1:0] win_start
);
  import sw_score_pkg::*;

  win_state_e       state_q, state_d;
  logic [POS_W-1:0] start_q, end_q;
  logic             at_start;

  assign at_start  = (ref_pos == start_q);
  assign busy      = (state_q != ST_IDLE);
  assign accept    = (state_q == ST_IDLE) && load_valid;
  assign step      = ref_valid &&
                     ((state_q == ST_SCORE) || ((state_q == ST_ARMED) && at_start));
  assign last      = step && (ref_pos == end_q);
  assign win_start = start_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_ARMED;
      ST_ARMED: if (step)   state_d = last ? ST_IDLE : ST_SCORE;
      ST_SCORE: if (last)   state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= '0;
      end_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        start_q <= load_start;
        end_q   <= load_end;
      end
    end
  end

  AST_BUSY_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load_valid)); // R2
  AST_BUSY_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load_valid) |=> ($stable(start_q) && $stable(end_q))); // R2

endmodule

// File: rtl/sw_best_tracker.sv
module sw_best_tracker #(
  parameter int unsigned SC_W  = 6,
  parameter int unsigned POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [POS_W-1:0] arm_pos,
  input  logic             step,
  input  logic [SC_W-1:0]  col_max,
  input  logic [POS_W-1:0] col_pos,
  output logic [SC_W-1:0]  best_nxt,
  output logic [POS_W-1:0] pos_nxt,
  output logic [SC_W-1:0]  best_q,
  output logic [POS_W-1:0] pos_q
);

  logic improve;

  // Strictly greater: an equal later column never displaces an earlier one.
  assign improve  = step && (col_max > best_q);
  assign best_nxt = improve ? col_max : best_q;
  assign pos_nxt  = improve ? col_pos : pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_q <= '0;
      pos_q  <= '0;
    end else if (arm) begin
      best_q <= '0;
      pos_q  <= arm_pos;
    end else begin
      best_q <= best_nxt;
      pos_q  <= pos_nxt;
    end
  end

  AST_BEST_NONDECREASING: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (best_q >= $past(best_q))); // R7
  AST_STALL_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !arm) |=> ($stable(pos_q) && $stable(best_q))); // R10

endmodule

// File: rtl/sw_stream_scorer.sv
module sw_stream_scorer #(
  parameter int unsigned READ_LEN_MAX = 32,
  parameter int unsigned POS_W        = 32,
  localparam int unsigned LEN_W       = $clog2(READ_LEN_MAX + 1),
  localparam int unsigned SC_W        = $clog2(2 * READ_LEN_MAX + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_valid,
  input  logic [LEN_W-1:0]          load_len,
  input  logic [2*READ_LEN_MAX-1:0] load_read,
  input  logic [POS_W-1:0]          load_start,
  input  logic [POS_W-1:0]          load_end,
  input  logic                      ref_valid,
  input  logic [1:0]                ref_nt,
  input  logic [POS_W-1:0]          ref_pos,
  output logic                      busy,
  output logic                      res_valid,
  output logic [SC_W-1:0]           res_score,
  output logic [POS_W-1:0]          res_pos
);

  logic                      accept_w, step_w, last_w;
  logic [POS_W-1:0]          win_start_w;
  logic [2*READ_LEN_MAX-1:0] read_q;
  logic [LEN_W-1:0]          len_q;
  logic [SC_W-1:0]           h_new_w [READ_LEN_MAX];
  logic [SC_W-1:0]           h_q_w   [READ_LEN_MAX];
  logic [SC_W-1:0]           col_max_w;
  logic [SC_W-1:0]           best_nxt_w, best_q_w;
  logic [POS_W-1:0]          pos_nxt_w, pos_q_w;
  logic [SC_W:0]             score_cap_w;

  sw_window_ctrl #(.POS_W(POS_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .load_start (load_start),
    .load_end   (load_end),
    .ref_valid  (ref_valid),
    .ref_pos    (ref_pos),
    .accept     (accept_w),
    .step       (step_w),
    .last       (last_w),
    .busy       (busy),
    .win_start  (win_start_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      read_q <= '0;
      len_q  <= '0;
    end else if (accept_w) begin
      read_q <= load_read;
      len_q  <= load_len;
    end
  end

  for (genvar i = 0; i < READ_LEN_MAX; i++) begin : g_row
    localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
    logic [SC_W-1:0] diag_w, up_w;
    logic            en_w;

    assign en_w = (IDX < len_q);

    if (i == 0) begin : g_first
      assign diag_w = '0;
      assign up_w   = '0;
    end else begin : g_chain
      assign diag_w = h_q_w[i-1];
      assign up_w   = h_new_w[i-1];
    end

    sw_cell #(.SC_W(SC_W), .ROW(i)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept_w),
      .step    (step_w),
      .en      (en_w),
      .read_nt (read_q[2*i +: 2]),
      .ref_nt  (ref_nt),
      .diag_in (diag_w),
      .up_in   (up_w),
      .h_new   (h_new_w[i]),
      .h_q     (h_q_w[i])
    );
  end

  always_comb begin
    col_max_w = '0;
    for (int i = 0; i < READ_LEN_MAX; i++) begin
      if (h_new_w[i] > col_max_w) col_max_w = h_new_w[i];
    end
  end

  sw_best_tracker #(.SC_W(SC_W), .POS_W(POS_W)) u_best (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (accept_w),
    .arm_pos  (load_start),
    .step     (step_w),
    .col_max  (col_max_w),
    .col_pos  (ref_pos),
    .best_nxt (best_nxt_w),
    .pos_nxt  (pos_nxt_w),
    .best_q   (best_q_w),
    .pos_q    (pos_q_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_score <= '0;
      res_pos   <= '0;
    end else begin
      res_valid <= last_w;
      if (last_w) begin
        res_score <= best_nxt_w;
        res_pos   <= pos_nxt_w;
      end
    end
  end

  assign score_cap_w = (SC_W + 1)'(len_q) << 1;

  AST_RES_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R9
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy); // R9
  AST_RES_SCORE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ({1'b0, res_score} <= score_cap_w)); // R11
  AST_START_NOT_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_pos >= win_start_w)); // R3

endmodule

// File: tb/sim_sw_stream_scorer.sv
`timescale 1ns/1ps
module sim_sw_stream_scorer;
  localparam int MAXL = 8;
  localparam int PW   = 16;
  localparam int LW   = $clog2(MAXL + 1);
  localparam int SW   = $clog2(2 * MAXL + 1);
  localparam int POS0 = 100;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            load_valid = 1'b0;
  logic [LW-1:0]   load_len = '0;
  logic [2*MAXL-1:0] load_read = '0;
  logic [PW-1:0]   load_start = '0, load_end = '0;
  logic            ref_valid = 1'b0;
  logic [1:0]      ref_nt = '0;
  logic [PW-1:0]   ref_pos = '0;
  logic            busy, res_valid;
  logic [SW-1:0]   res_score;
  logic [PW-1:0]   res_pos;

  int n_checks = 0;
  int n_fail   = 0;
  int refq [0:63];
  int refn = 0;
  int pulses, got_score, got_pos;

  always #2.5 clk = ~clk;

  sw_stream_scorer #(.READ_LEN_MAX(MAXL), .POS_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_len(load_len),
    .load_read(load_read), .load_start(load_start), .load_end(load_end),
    .ref_valid(ref_valid), .ref_nt(ref_nt), .ref_pos(ref_pos),
    .busy(busy), .res_valid(res_valid), .res_score(res_score), .res_pos(res_pos)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int enc(input byte c);
    case (c)
      "A": return 0;
      "C": return 1;
      "G": return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [2*MAXL-1:0] pack_read(input string s);
    logic [2*MAXL-1:0] v = '0;
    for (int i = 0; i < s.len() && i < MAXL; i++) v[2*i +: 2] = 2'(enc(s[i]));
    return v;
  endfunction

  task automatic set_ref(input string s);
    refn = s.len();
    for (int i = 0; i < refn; i++) refq[i] = enc(s[i]);
  endtask

  // Independent matrix fill over the window, earliest column kept on ties.
  task automatic model(input string rd, input int len, input int st, input int en,
                       output int best, output int bpos);
    int hp [0:MAXL];
    int hc [0:MAXL];
    int d, v;
    for (int i = 0; i <= MAXL; i++) hp[i] = 0;
    best = 0;
    bpos = st;
    for (int p = st; p <= en; p++) begin
      hc[0] = 0;
      for (int i = 1; i <= len; i++) begin
        d = hp[i-1] + ((enc(rd[i-1]) == refq[p-POS0]) ? 2 : -1);
        v = 0;
        if (d > v) v = d;
        if (hp[i] - 1 > v) v = hp[i] - 1;
        if (hc[i-1] - 1 > v) v = hc[i-1] - 1;
        hc[i] = v;
        if (v > best) begin best = v; bpos = p; end
      end
      for (int i = 0; i <= len; i++) hp[i] = hc[i];
    end
  endtask

  task automatic sample();
    if (res_valid) begin
      pulses++;
      got_score = int'(res_score);
      got_pos   = int'(res_pos);
    end
  endtask

  task automatic run(input string rd, input int len, input int st, input int en,
                     input bit stall, input bit rogue, input string tag);
    int eb, ep;
    model(rd, len, st, en, eb, ep);
    pulses = 0; got_score = -1; got_pos = -1;
    @(negedge clk);
    load_valid = 1'b1; load_len = LW'(len); load_read = pack_read(rd);
    load_start = PW'(st); load_end = PW'(en);
    @(negedge clk);
    load_valid = 1'b0;
    chk(busy == 1'b1, {"R2 busy after load ", tag}, int'(busy), 1);
    for (int k = 0; k < refn; k++) begin
      if (stall && (k % 2 == 0)) begin
        sample();
        ref_valid = 1'b0; ref_nt = 2'(3 - refq[k]); ref_pos = PW'(POS0 + k);
        @(negedge clk);
      end
      sample();
      load_valid = 1'b0;
      if (rogue && k == 3) begin
        load_valid = 1'b1; load_len = LW'(MAXL); load_read = pack_read("TTTTTTTT");
        load_start = PW'(POS0); load_end = PW'(POS0);
      end
      ref_valid = 1'b1; ref_nt = 2'(refq[k]); ref_pos = PW'(POS0 + k);
      @(negedge clk);
    end
    load_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      sample();
      ref_valid = 1'b0;
      @(negedge clk);
    end
    chk(pulses == 1, {"R9 single result pulse ", tag}, pulses, 1);
    chk(got_score == eb, {"R7 best score ", tag}, got_score, eb);
    chk(got_pos == ep, {"R7 best position ", tag}, got_pos, ep);
    chk(busy == 1'b0, {"R9 idle after result ", tag}, int'(busy), 0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
    chk(res_valid == 1'b0, "R1 res_valid at reset", int'(res_valid), 0);
  endtask

  task automatic t_exact_and_busy_load();
    set_ref("TTTACGTTGCATTT");
    run("ACGTTGCA", 8, 100, 113, 1'b0, 1'b1, "R11 exact, R2 rogue load");
    chk(got_score == 16, "R11 full-length match", got_score, 16);
    chk(got_pos == 110, "R11 full-length match pos", got_pos, 110);
  endtask

  task automatic t_mismatch();
    set_ref("GGACGAACGAGG");
    run("ACGTACGA", 8, 100, 111, 1'b0, 1'b0, "R4 mismatch");
  endtask

  task automatic t_gap();
    set_ref("CAACCGTTAC");
    run("AACCGGTT", 8, 100, 109, 1'b0, 1'b0, "R4 gap");
  endtask

  task automatic t_short_len();
    set_ref("AAAAGTCAAAA");
    run("GTCAAAAA", 3, 100, 110, 1'b0, 1'b0, "R5 short read");
    chk(got_score == 6, "R5 only first bases score", got_score, 6);
  endtask

  task automatic t_pre_start();
    set_ref("CATGGGGGCAG");
    run("CATAAAAA", 3, 103, 110, 1'b0, 1'b0, "R3 before start");
    chk(got_score == 4, "R3 match before start ignored", got_score, 4);
  endtask

  task automatic t_after_end();
    set_ref("GGGGCATGGG");
    run("CATTTTTT", 3, 100, 104, 1'b0, 1'b0, "R6 after end");
    chk(got_score == 2 && got_pos == 104, "R6 inclusive end, later bases ignored", got_score, 2);
  endtask

  task automatic t_tie();
    set_ref("TGATTGAT");
    run("GA", 2, 100, 107, 1'b0, 1'b0, "R7 tie");
    chk(got_pos == 102, "R7 earliest of equal maxima", got_pos, 102);
  endtask

  task automatic t_zero();
    set_ref("TTTTTT");
    run("AAAAAAAA", 8, 101, 104, 1'b0, 1'b0, "R8 no score");
    chk(got_score == 0 && got_pos == 101, "R8 zero at start", got_pos, 101);
  endtask

  task automatic t_stall();
    set_ref("GGACGAACGAGG");
    run("ACGTACGA", 8, 100, 111, 1'b1, 1'b0, "R10 stalled stream");
  endtask

  task automatic t_single_column();
    set_ref("GCG");
    run("CAAAAAAA", 1, 101, 101, 1'b0, 1'b0, "R9 single column reload");
    chk(got_score == 2 && got_pos == 101, "R6 one-column window", got_score, 2);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact_and_busy_load();
    t_mismatch();
    t_gap();
    t_short_len();
    t_pre_start();
    t_after_end();
    t_tie();
    t_zero();
    t_stall();
    t_single_column();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule